// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Controller

This block sits between a synchronous host and an asynchronous parallel mask ROM that can be strapped for either 16-bit words or 8-bit bytes. The host presents one request at a time: a byte-granular address and a width select. The controller drives the ROM's chip enable, output enable, width strap and word address. It waits out the access intervals with a cycle counter and then returns the sampled data with a one-cycle valid pulse.

One ROM pin has two roles. In byte mode it is the lowest address bit and the controller drives it. In word mode it is the top data bit and the ROM drives it. The controller changes the width strap only while the ROM is deselected. It holds the pin released until the ROM's output float time has passed. The top quarter of the address space, where both of the two highest word-address bits are set, holds no data. Responses to those addresses carry an error flag.

All wait counts come from a clock-period parameter in nanoseconds. Each count is the required time divided by the period, rounded up, plus one margin cycle. With a 10 ns clock, an access lasts 13 cycles and the float wait lasts 6 cycles.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While `rst_ni` is low, `rom_ce_no`=1, `rom_oe_no`=1, `rdy_o`=1, `rsp_vld_o`=0, `rom_wide_o`=1 (word strap) and `rom_lsb_oe_o`=0.
- R2: In word mode (`mode_i`=1), `rom_addr_o` equals `addr_i[21:1]` and `addr_i[0]` is ignored. The response is `{rom_d15_i, rom_data_i[14:0]}`.
- R3: In byte mode (`mode_i`=0), `rom_addr_o` equals `addr_i[21:1]` and the shared pin is driven with `addr_i[0]` (0 selects the low byte of the word, 1 the high byte). The response is `{8'h00, rom_data_i[7:0]}`, and `rom_data_i[14:8]` is ignored.
- R4: `rsp_err_o` is 1 with the response exactly when `addr_i[21]` and `addr_i[20]` were both 1.
- R5: Chip enable and output enable fall together and stay low for N_ACC cycles. N_ACC is the largest of ceil(t/P)+1 over 120 ns address access, 120 ns enable access, 60 ns output-enable access and 120 ns cycle time, which gives 13 at P=10. Data is sampled at the last edge. Address and shared pin stay stable while enabled.
- R6: `rdy_o` is high only when idle. Without a width change, `rsp_vld_o` rises N_ACC edges after the accepting edge. `rdy_o` returns N_FLT = ceil(50/P)+1 cycles after `rsp_vld_o`, which gives 6 at P=10.
- R7: `rsp_vld_o` is a single-cycle pulse.
- R8: `rom_lsb_oe_o` is high only when `rom_wide_o`=0, and never while the ROM may still be driving the pin, including its 50 ns float time.
- R9: `rom_wide_o` changes only while chip enable is high. A request whose width differs from the current strap waits an extra N_FLT cycles before chip enable falls.
- R10: Chip enable stays high for at least N_FLT cycles between two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, accepted when `rdy_o` is high |
| rdy_o | output | 1 | Idle and able to accept a request |
| mode_i | input | 1 | Width select: 1 word, 0 byte |
| addr_i | input | 22 | Byte address; bit 0 picks the byte lane in byte mode |
| rsp_vld_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | 16 | Returned data |
| rsp_err_o | output | 1 | Address fell in the empty region |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |
| rom_wide_o | output | 1 | ROM width strap: 1 word, 0 byte |
| rom_addr_o | output | 21 | ROM word address |
| rom_lsb_o | output | 1 | Shared pin value when driven (byte lane select) |
| rom_lsb_oe_o | output | 1 | Controller drives the shared pin |
| rom_d15_i | input | 1 | Shared pin as read back (top data bit in word mode) |
| rom_data_i | input | 15 | ROM data bits 14..0 |

## Verification
Suppose the wait counter is loaded short or the sequencer leaves the access state early. The response then carries unsettled ROM data, and its latency in cycles is wrong on the very first read. A wrong strap or a wrong pin-enable state shows in the same cycle as drive contention against a ROM model that keeps the pin for its float time. It also shows as the wrong byte lane in the next response. A lost or misrouted address-hole decode shows as a wrong error flag on the response of that request.

// File: rtl/rom_rd_pkg.sv
`timescale 1ns/1ps
package rom_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MODE, ST_ACC, ST_FLT} rd_state_e;

  // wait cycles for an interval: ceil(t/p) plus one margin cycle
  function automatic int unsigned wait_cycles(int unsigned t_ns, int unsigned p_ns);
    return (t_ns + p_ns - 1) / p_ns + 1;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rom_rd_wait.sv
`timescale 1ns/1ps
module rom_rd_wait #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rom_rd_addr.sv
`timescale 1ns/1ps
module rom_rd_addr #(
  parameter int unsigned AW = 21
) (
  input  logic [AW:0]   addr_i,
  input  logic          wide_i,
  output logic [AW-1:0] word_o,
  output logic          lsb_o,
  output logic          hole_o
);
  assign word_o = addr_i[AW:1];
  assign lsb_o  = addr_i[0] & ~wide_i;
  // top two word-address bits both set: no stored data
  assign hole_o = &addr_i[AW -: 2];
endmodule

// File: rtl/rom_rd_lane.sv
`timescale 1ns/1ps
module rom_rd_lane #(
  parameter int unsigned DW = 16
) (
  input  logic          wide_i,
  input  logic [DW-2:0] bus_i,
  input  logic          top_i,
  output logic [DW-1:0] data_o
);
  localparam int unsigned BW = DW / 2;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i < BW) begin : g_low
      assign data_o[i] = bus_i[i];
    end else if (i == DW - 1) begin : g_top
      assign data_o[i] = wide_i & top_i;
    end else begin : g_high
      assign data_o[i] = wide_i & bus_i[i];
    end
  end
endmodule

// File: rtl/rom_rd_ctrl.sv
`timescale 1ns/1ps
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int unsigned AW            = 21,
  parameter int unsigned DW            = 16,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_ADDR_NS     = 120,
  parameter int unsigned T_CE_NS       = 120,
  parameter int unsigned T_OE_NS       = 60,
  parameter int unsigned T_CYC_NS      = 120,
  parameter int unsigned T_FLOAT_NS    = 50,
  parameter bit          RST_WIDE      = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          rdy_o,
  input  logic          mode_i,
  input  logic [AW:0]   addr_i,
  output logic          rsp_vld_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          rsp_err_o,
  output logic          rom_ce_no,
  output logic          rom_oe_no,
  output logic          rom_wide_o,
  output logic [AW-1:0] rom_addr_o,
  output logic          rom_lsb_o,
  output logic          rom_lsb_oe_o,
  input  logic          rom_d15_i,
  input  logic [DW-2:0] rom_data_i
);
  localparam int unsigned N_ACC = max2(max2(wait_cycles(T_ADDR_NS, CLK_PERIOD_NS),
                                            wait_cycles(T_CE_NS, CLK_PERIOD_NS)),
                                       max2(wait_cycles(T_OE_NS, CLK_PERIOD_NS),
                                            wait_cycles(T_CYC_NS, CLK_PERIOD_NS)));
  localparam int unsigned N_FLT = wait_cycles(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int unsigned CW    = $clog2(max2(N_ACC, N_FLT) + 1);

  rd_state_e     state_q;
  logic          wide_q;
  logic [AW-1:0] addr_q;
  logic          lsb_q;
  logic          hole_q;
  logic          vld_q;
  logic [DW-1:0] data_q;
  logic          err_q;

  logic [AW-1:0] word_w;
  logic          lsb_w;
  logic          hole_w;
  logic [DW-1:0] lane_w;
  logic          ld_w;
  logic [CW-1:0] ld_val_w;
  logic          done_w;
  logic          accept_w;

  rom_rd_addr #(.AW(AW)) u_addr (
    .addr_i (addr_i),
    .wide_i (mode_i),
    .word_o (word_w),
    .lsb_o  (lsb_w),
    .hole_o (hole_w)
  );

  rom_rd_lane #(.DW(DW)) u_lane (
    .wide_i (wide_q),
    .bus_i  (rom_data_i),
    .top_i  (rom_d15_i),
    .data_o (lane_w)
  );

  rom_rd_wait #(.W(CW)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld_w),
    .val_i  (ld_val_w),
    .done_o (done_w)
  );

  assign accept_w = (state_q == ST_IDLE) && req_i;

  always_comb begin
    ld_w     = 1'b0;
    ld_val_w = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        ld_w     = 1'b1;
        ld_val_w = (mode_i != wide_q) ? CW'(N_FLT - 1) : CW'(N_ACC - 1);
      end
      ST_MODE: if (done_w) begin
        ld_w     = 1'b1;
        ld_val_w = CW'(N_ACC - 1);
      end
      ST_ACC: if (done_w) begin
        ld_w     = 1'b1;
        ld_val_w = CW'(N_FLT - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wide_q  <= RST_WIDE;
      addr_q  <= '0;
      lsb_q   <= 1'b0;
      hole_q  <= 1'b0;
      vld_q   <= 1'b0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          addr_q <= word_w;
          lsb_q  <= lsb_w;
          hole_q <= hole_w;
          if (mode_i != wide_q) begin
            // strap flips with the ROM deselected, then float time elapses
            wide_q  <= mode_i;
            state_q <= ST_MODE;
          end else begin
            state_q <= ST_ACC;
          end
        end
        ST_MODE: if (done_w) state_q <= ST_ACC;
        ST_ACC: if (done_w) begin
          data_q  <= lane_w;
          err_q   <= hole_q;
          vld_q   <= 1'b1;
          state_q <= ST_FLT;
        end
        ST_FLT: if (done_w) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rdy_o        = (state_q == ST_IDLE);
  assign rsp_vld_o    = vld_q;
  assign rsp_data_o   = data_q;
  assign rsp_err_o    = err_q;
  assign rom_ce_no    = (state_q != ST_ACC);
  assign rom_oe_no    = (state_q != ST_ACC);
  assign rom_wide_o   = wide_q;
  assign rom_addr_o   = addr_q;
  assign rom_lsb_o    = lsb_q;
  assign rom_lsb_oe_o = ~wide_q && (state_q != ST_MODE);
endmodule

// File: rtl/rom_rd_ctrl_chk.sv
`timescale 1ns/1ps
module rom_rd_ctrl_chk #(
  parameter int unsigned AW    = 21,
  parameter int unsigned DW    = 16,
  parameter int unsigned N_ACC = 13,
  parameter int unsigned N_FLT = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rdy_o,
  input logic          rsp_vld_o,
  input logic [DW-1:0] rsp_data_o,
  input logic          rsp_err_o,
  input logic          rom_ce_no,
  input logic          rom_oe_no,
  input logic          rom_wide_o,
  input logic [AW-1:0] rom_addr_o,
  input logic          rom_lsb_o,
  input logic          rom_lsb_oe_o
);
  localparam int unsigned SAT = 1 << 16;
  int unsigned lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= 0;
      hi_cnt <= N_FLT;
    end else begin
      lo_cnt <= rom_ce_no ? 0 : ((lo_cnt < SAT) ? lo_cnt + 1 : lo_cnt);
      hi_cnt <= !rom_ce_no ? 0 : ((hi_cnt < SAT) ? hi_cnt + 1 : hi_cnt);
    end
  end

  p_enables_paired_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_oe_no == rom_ce_no);
  p_access_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rom_ce_no) |-> lo_cnt >= N_ACC);
  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_ce_no && !$past(rom_ce_no)) |-> ($stable(rom_addr_o) && $stable(rom_lsb_o)));
  p_err_hole_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |-> (rsp_err_o == (&rom_addr_o[AW-1 -: 2])));
  p_byte_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && !rom_wide_o) |-> (rsp_data_o[DW-1:DW/2] == '0));
  p_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |-> !rdy_o);
  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |=> !rsp_vld_o);
  p_no_contend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_lsb_oe_o |-> !rom_wide_o);
  p_strap_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_ce_no |-> $stable(rom_wide_o));
  p_float_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rom_ce_no) |-> hi_cnt >= N_FLT);
endmodule

bind rom_rd_ctrl rom_rd_ctrl_chk #(
  .AW(AW), .DW(DW), .N_ACC(N_ACC), .N_FLT(N_FLT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rdy_o        (rdy_o),
  .rsp_vld_o    (rsp_vld_o),
  .rsp_data_o   (rsp_data_o),
  .rsp_err_o    (rsp_err_o),
  .rom_ce_no    (rom_ce_no),
  .rom_oe_no    (rom_oe_no),
  .rom_wide_o   (rom_wide_o),
  .rom_addr_o   (rom_addr_o),
  .rom_lsb_o    (rom_lsb_o),
  .rom_lsb_oe_o (rom_lsb_oe_o)
);

// File: tb/rom_rd_ctrl_test.sv
`timescale 1ns/1ps
module rom_rd_ctrl_test;
  localparam int N_ACC = 13;  // max(ceil(120/10),ceil(60/10))+1
  localparam int N_FLT = 6;   // ceil(50/10)+1
  localparam longint LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        mode = 1'b1;
  logic [21:0] addr = '0;
  logic        rdy_o, rsp_vld_o, rsp_err_o;
  logic [15:0] rsp_data_o;
  logic        rom_ce_no, rom_oe_no, rom_wide_o, rom_lsb_o, rom_lsb_oe_o;
  logic [20:0] rom_addr_o;
  logic        rom_d15 = 1'b0;
  logic [14:0] rom_data = '0;

  always #5 clk = ~clk;

  rom_rd_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rdy_o(rdy_o), .mode_i(mode),
    .addr_i(addr), .rsp_vld_o(rsp_vld_o), .rsp_data_o(rsp_data_o),
    .rsp_err_o(rsp_err_o), .rom_ce_no(rom_ce_no), .rom_oe_no(rom_oe_no),
    .rom_wide_o(rom_wide_o), .rom_addr_o(rom_addr_o), .rom_lsb_o(rom_lsb_o),
    .rom_lsb_oe_o(rom_lsb_oe_o), .rom_d15_i(rom_d15), .rom_data_i(rom_data)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int contend = 0, strap_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rom_word(input logic [20:0] wa);
    return {wa[7:0], wa[15:8]} ^ {11'h2C7, wa[20:16]};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural ROM: data valid only after the access intervals
  longint t_addr = -1000, t_ce = -1000, t_oe = -1000, t_off = -1000;
  logic [20:0] p_addr = '0;
  logic p_lsb = 1'b0, p_ce = 1'b1, p_oe = 1'b1, p_wide = 1'b1;
  always @(negedge clk) begin
    longint now, e;
    logic [15:0] w;
    logic [7:0] b;
    logic ok, lsb;
    now = longint'($time);
    e = now - 5;
    lsb = rom_lsb_oe_o ? rom_lsb_o : ~p_lsb;
    if (rom_addr_o != p_addr || (!rom_wide_o && lsb != p_lsb)) t_addr = e;
    if (rom_ce_no != p_ce) begin if (!rom_ce_no) t_ce = e; else t_off = e; end
    if (rom_oe_no != p_oe) begin if (!rom_oe_no) t_oe = e; else t_off = e; end
    if (!rom_ce_no && rom_wide_o != p_wide) strap_bad++;
    if (rom_lsb_oe_o && p_wide && ((!rom_ce_no && !rom_oe_no) || (now - t_off < 50))) contend++;
    p_addr = rom_addr_o; p_lsb = lsb; p_ce = rom_ce_no; p_oe = rom_oe_no; p_wide = rom_wide_o;
    ok = !rom_ce_no && !rom_oe_no && (now - t_addr >= 120) && (now - t_ce >= 120)
         && (now - t_oe >= 60) && rom_lsb_oe_o != rom_wide_o;
    w = (&rom_addr_o[20:19]) ? 16'hDEAD : rom_word(rom_addr_o);
    b = lsb ? w[15:8] : w[7:0];
    if (!ok) begin
      rom_data <= 15'h5EAD; rom_d15 <= 1'b1;
    end else if (rom_wide_o) begin
      rom_data <= w[14:0]; rom_d15 <= w[15];
    end else begin
      rom_data <= {7'h55, b}; rom_d15 <= 1'b0;
    end
  end

  typedef struct {
    logic [15:0] data;
    logic        err;
    bit          cmp;
    int          lat;
    int          acc;
  } exp_t;
  exp_t q[$];
  bit cur_wide = 1'b1;

  task automatic do_read(input bit wide, input logic [21:0] a);
    exp_t e;
    logic [15:0] w;
    while (!rdy_o) @(negedge clk);
    w = rom_word(a[21:1]);
    e.data = wide ? w : {8'h00, a[0] ? w[15:8] : w[7:0]};
    e.err  = a[21] & a[20];
    e.cmp  = !e.err;
    e.lat  = N_ACC + ((wide != cur_wide) ? N_FLT : 0);
    e.acc  = cyc + 1;
    cur_wide = wide;
    q.push_back(e);
    req = 1'b1; mode = wide; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor: pop and compare responses, check ready recovery
  int last_vld = -1;
  logic prev_rdy = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_vld_o) begin
        if (q.size() == 0) chk(1'b0, "R7 unexpected response", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          if (e.cmp) chk(rsp_data_o == e.data, "R2/R3 data", rsp_data_o, e.data);
          chk(rsp_err_o == e.err, "R4 error flag", rsp_err_o, e.err);
          chk(cyc - e.acc == e.lat, "R5 R6 R9 latency", cyc - e.acc, e.lat);
        end
        last_vld = cyc;
      end
      if (rdy_o && !prev_rdy && last_vld >= 0)
        chk(cyc - last_vld == N_FLT, "R6 R10 ready recovery", cyc - last_vld, N_FLT);
      prev_rdy = rdy_o;
    end
  end

  initial begin
    bit timeout = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        // R1 reset state: ce,oe,rdy,vld,wide,lsb_oe
        chk({rom_ce_no, rom_oe_no, rdy_o, rsp_vld_o, rom_wide_o, rom_lsb_oe_o} == 6'b111010,
            "R1 reset", {rom_ce_no, rom_oe_no, rdy_o, rsp_vld_o, rom_wide_o, rom_lsb_oe_o}, 6'b111010);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 word reads, bit 0 ignored
        do_read(1'b1, 22'h000002);
        do_read(1'b1, 22'h0ABCDF);
        do_read(1'b1, 22'h13FFFE);
        // R3 byte reads (first one changes the strap, R9)
        do_read(1'b0, 22'h0ABCDE);
        do_read(1'b0, 22'h0ABCDF);
        do_read(1'b0, 22'h1F0001);
        // R4 hole and near-hole
        do_read(1'b0, 22'h300001);
        do_read(1'b0, 22'h200001);
        do_read(1'b0, 22'h100000);
        // back to word, then hole in word mode
        do_read(1'b1, 22'h3FFFFE);
        do_read(1'b1, 22'h2FFFFE);
        do_read(1'b0, 22'h012345);
        do_read(1'b1, 22'h012345);
        while (q.size() != 0 || !rdy_o) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(contend == 0, "R8 shared pin contention", contend, 0);
        chk(strap_bad == 0, "R9 strap change while enabled", strap_bad, 0);
      end
      begin
        while (cyc < LIMIT) @(negedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "watchdog expired", cyc, LIMIT);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule